// File: doc/BRIEF.md
# Cycle-Stealing Block DMA Controller

This block moves a contiguous block of 16-bit words between a peripheral controller and memory by stealing one bus cycle per word. The CPU programs it through programmed-I/O commands: it loads a 15-bit current-address register and a 15-bit final-address register, then starts the transfer. From then on, each word request from the peripheral makes the block wait for bus priority. It then raises a single trap strobe with the current address on the shared address bus, and advances the address. Data never passes through the block. It travels directly between the peripheral and memory.

The block length comes from comparing the two addresses for equality, not from a word counter. The word at the final address is still transferred, and the controller then drops to not-busy with the current register left at the last address used. A peripheral may also stop the transfer early. That abnormal stop is latched as a status flag that can be sensed separately. Bus priority is passed down a daisy chain. The controller holds priority back only while it has a word pending.

Top module: `blk_dma_ctrl`

## Requirements
- R1: After reset the controller is not busy, the abnormal-stop flag is clear, the current address reads as 0, and no trap strobe is active.
- R2: A load command (kind 0) to device BASE_DEV (default octal 020) writes cmd_data into the current address, and a load to BASE_DEV+1 writes the final address. A read command (kind 1) to BASE_DEV returns, one cycle later, resp_valid high and resp_data = {1'b0, current address}.
- R3: An external-control command (kind 2) to BASE_DEV activates the controller. A sense command (kind 3) to BASE_DEV then returns resp_data[0]=0 (not-busy false), and dev_connect is high.
- R4: Each word request while active yields exactly one trap strobe, one cycle wide. In that cycle bus_addr equals the current address, and the next word uses that address plus one.
- R5: The word at the final address is transferred. After that trap the controller is not busy (sense BASE_DEV returns 1), dev_connect is low, and the current address reads back equal to the final address.
- R6: When dir_out is 1 the strobe is trap_out, and when it is 0 the strobe is trap_in. The two are never high together.
- R7: A trap is issued only after a cycle with pri_in high. pri_out equals pri_in while no word is pending and is held low while one is.
- R8: dev_stop while active ends the transfer. The controller goes not busy, a sense (kind 3) to BASE_DEV+1 returns resp_data[0]=1, and the current address keeps the next unused address. The flag clears on the next activation.
- R9: A word request while the controller is not active produces no trap and leaves the current address unchanged.
- R10: An external-control command to BASE_DEV+1 initializes the controller. It clears busy, the abnormal-stop flag, any pending word and the current address.
- R11: Commands to any device address other than BASE_DEV and BASE_DEV+1 change no state and give no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Programmed-I/O command strobe |
| cmd_kind | input | 2 | 0 load, 1 read, 2 external control, 3 sense |
| cmd_dev | input | DEV_W | Device address of the command |
| cmd_data | input | AW | Address value for load commands |
| resp_valid | output | 1 | Read or sense response valid |
| resp_data | output | DW | Response word |
| xfer_req | input | 1 | Peripheral word request pulse |
| dir_out | input | 1 | 1: memory to device, 0: device to memory |
| dev_stop | input | 1 | Peripheral abnormal-stop request |
| pri_in | input | 1 | Priority from upstream |
| pri_out | output | 1 | Priority to downstream |
| trap_in | output | 1 | Cycle-steal strobe, device to memory |
| trap_out | output | 1 | Cycle-steal strobe, memory to device |
| bus_addr | output | AW | Word address during a strobe, else 0 |
| dev_connect | output | 1 | Peripheral connected (controller active) |

## Verification
The hardest situation to reach is a word that sits pending while upstream priority is withheld for several cycles. pri_out must stay low during that wait, and the trap must follow only a cycle with priority present. The bench reaches it by pulsing each request and then gating pri_in randomly from a fixed seed, so the waits vary in length. Abnormal stops in mid-block, requests while idle, and single-word blocks (start equal to final) are driven directly, and the readable address and status are checked after each one.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    CMD_LOAD  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_EXC   = 2'd2,
    CMD_SENSE = 2'd3
  } cmd_kind_e;
endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode #(
  parameter int DEV_W = 6,
  parameter logic [DEV_W-1:0] BASE_DEV = 6'o20
) (
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_kind,
  input  logic [DEV_W-1:0] cmd_dev,
  output logic             ld_cur,
  output logic             ld_fin,
  output logic             rd_cur,
  output logic             act_stb,
  output logic             init_stb,
  output logic             sns_idle,
  output logic             sns_abn
);
  import dma_pkg::*;
  localparam logic [DEV_W-2:0] PAIR = BASE_DEV[DEV_W-1:1];

  logic      hit;
  logic      sel_hi;
  cmd_kind_e kind;

  always_comb begin
    kind     = cmd_kind_e'(cmd_kind);
    hit      = cmd_valid && (cmd_dev[DEV_W-1:1] == PAIR);
    sel_hi   = cmd_dev[0];
    ld_cur   = hit && (kind == CMD_LOAD)  && !sel_hi;
    ld_fin   = hit && (kind == CMD_LOAD)  &&  sel_hi;
    rd_cur   = hit && (kind == CMD_READ)  && !sel_hi;
    act_stb  = hit && (kind == CMD_EXC)   && !sel_hi;
    init_stb = hit && (kind == CMD_EXC)   &&  sel_hi;
    sns_idle = hit && (kind == CMD_SENSE) && !sel_hi;
    sns_abn  = hit && (kind == CMD_SENSE) &&  sel_hi;
  end
endmodule

// File: rtl/dma_addr_regs.sv
module dma_addr_regs #(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          ld_cur,
  input  logic          ld_fin,
  input  logic [AW-1:0] ld_data,
  input  logic          step,
  output logic [AW-1:0] cur,
  output logic          at_end,
  output logic [AW-1:0] bus_addr
);
  logic [AW-1:0] fin;

  assign at_end = (cur == fin);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur      <= '0;
      fin      <= '0;
      bus_addr <= '0;
    end else begin
      bus_addr <= step ? cur : '0;
      if (clr)                cur <= '0;
      else if (ld_cur)        cur <= ld_data;
      else if (step && !at_end) cur <= cur + 1'b1;
      if (ld_fin) fin <= ld_data;
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (step && !at_end && !clr && !ld_cur) |=> (cur == $past(cur) + 1'b1)); // R4
  AST_ADDR_ON_BUS: assert property (@(posedge clk) disable iff (rst)
    step |=> (bus_addr == $past(cur))); // R4
endmodule

// File: rtl/dma_seq.sv
module dma_seq (
  input  logic clk,
  input  logic rst,
  input  logic act_stb,
  input  logic init_stb,
  input  logic xfer_req,
  input  logic dev_stop,
  input  logic pri_in,
  input  logic dir_out,
  input  logic at_end,
  output logic active,
  output logic abn,
  output logic step,
  output logic trap_in,
  output logic trap_out,
  output logic pri_out
);
  logic pending;

  assign step    = pending && active && pri_in;
  assign pri_out = pri_in && !pending;

  always_ff @(posedge clk) begin
    if (rst || init_stb) begin
      active   <= 1'b0;
      abn      <= 1'b0;
      pending  <= 1'b0;
      trap_in  <= 1'b0;
      trap_out <= 1'b0;
    end else begin
      trap_in  <= step && !dir_out;
      trap_out <= step &&  dir_out;
      if (act_stb) begin
        active  <= 1'b1;
        abn     <= 1'b0;
        pending <= 1'b0;
      end else if (active && dev_stop) begin
        active  <= 1'b0;
        abn     <= 1'b1;
        pending <= 1'b0;
      end else if (step) begin
        pending <= 1'b0;
        if (at_end) active <= 1'b0;
      end else if (xfer_req && active && !pending) begin
        pending <= 1'b1;
      end
    end
  end

  AST_ONE_DIR: assert property (@(posedge clk) disable iff (rst)
    !(trap_in && trap_out)); // R6
  AST_TRAP_AFTER_PRI: assert property (@(posedge clk) disable iff (rst)
    (trap_in || trap_out) |-> $past(pri_in)); // R7
  AST_PRI_HELD: assert property (@(posedge clk) disable iff (rst)
    pending |-> !pri_out); // R7
  AST_IDLE_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
    (!active && !pending) |=> !(trap_in || trap_out)); // R9
  AST_END_IDLE: assert property (@(posedge clk) disable iff (rst)
    (step && at_end && !act_stb && !init_stb && !dev_stop) |=> !active); // R5
  AST_STOP_FLAG: assert property (@(posedge clk) disable iff (rst)
    (active && dev_stop && !act_stb && !init_stb) |=> (abn && !active)); // R8
endmodule

// File: rtl/blk_dma_ctrl.sv
module blk_dma_ctrl #(
  parameter int AW    = 15,
  parameter int DW    = 16,
  parameter int DEV_W = 6,
  parameter logic [DEV_W-1:0] BASE_DEV = 6'o20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_kind,
  input  logic [DEV_W-1:0] cmd_dev,
  input  logic [AW-1:0]    cmd_data,
  output logic             resp_valid,
  output logic [DW-1:0]    resp_data,
  input  logic             xfer_req,
  input  logic             dir_out,
  input  logic             dev_stop,
  input  logic             pri_in,
  output logic             pri_out,
  output logic             trap_in,
  output logic             trap_out,
  output logic [AW-1:0]    bus_addr,
  output logic             dev_connect
);
  localparam int PAD = DW - AW;

  logic ld_cur, ld_fin, rd_cur, act_stb, init_stb, sns_idle, sns_abn;
  logic active, abn, step, at_end;
  logic [AW-1:0] cur;

  dma_cmd_decode #(.DEV_W(DEV_W), .BASE_DEV(BASE_DEV)) u_dec (
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_dev(cmd_dev),
    .ld_cur(ld_cur), .ld_fin(ld_fin), .rd_cur(rd_cur),
    .act_stb(act_stb), .init_stb(init_stb),
    .sns_idle(sns_idle), .sns_abn(sns_abn)
  );

  dma_addr_regs #(.AW(AW)) u_addr (
    .clk(clk), .rst(rst), .clr(init_stb),
    .ld_cur(ld_cur), .ld_fin(ld_fin), .ld_data(cmd_data),
    .step(step), .cur(cur), .at_end(at_end), .bus_addr(bus_addr)
  );

  dma_seq u_seq (
    .clk(clk), .rst(rst), .act_stb(act_stb), .init_stb(init_stb),
    .xfer_req(xfer_req), .dev_stop(dev_stop), .pri_in(pri_in),
    .dir_out(dir_out), .at_end(at_end), .active(active), .abn(abn),
    .step(step), .trap_in(trap_in), .trap_out(trap_out), .pri_out(pri_out)
  );

  assign dev_connect = active;

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= rd_cur || sns_idle || sns_abn;
      if (rd_cur)        resp_data <= {{PAD{1'b0}}, cur};
      else if (sns_idle) resp_data <= {{(DW-1){1'b0}}, !active};
      else if (sns_abn)  resp_data <= {{(DW-1){1'b0}}, abn};
      else               resp_data <= '0;
    end
  end

  AST_RESP_ONLY_HIT: assert property (@(posedge clk) disable iff (rst)
    !(rd_cur || sns_idle || sns_abn) |=> !resp_valid); // R11
endmodule

// File: tb/blk_dma_ctrl_bench.sv
module blk_dma_ctrl_bench;
  localparam int AW = 15;
  localparam int DW = 16;
  localparam int DEV_W = 6;
  localparam logic [DEV_W-1:0] DEV_LO = 6'o20;
  localparam logic [DEV_W-1:0] DEV_HI = 6'o21;

  logic clk = 1'b0;
  logic rst;
  logic cmd_valid;
  logic [1:0] cmd_kind;
  logic [DEV_W-1:0] cmd_dev;
  logic [AW-1:0] cmd_data;
  logic resp_valid;
  logic [DW-1:0] resp_data;
  logic xfer_req, dir_out, dev_stop, pri_in;
  logic pri_out, trap_in, trap_out, dev_connect;
  logic [AW-1:0] bus_addr;

  int checks = 0;
  int fails  = 0;
  int unsigned seed = 32'd4242;

  always #2.5 clk = ~clk;

  blk_dma_ctrl u_blk_dma_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_dev(cmd_dev), .cmd_data(cmd_data), .resp_valid(resp_valid),
    .resp_data(resp_data), .xfer_req(xfer_req), .dir_out(dir_out),
    .dev_stop(dev_stop), .pri_in(pri_in), .pri_out(pri_out),
    .trap_in(trap_in), .trap_out(trap_out), .bus_addr(bus_addr),
    .dev_connect(dev_connect)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] start, input int idx);
    return start + AW'(idx);
  endfunction

  task automatic cmd(input logic [1:0] kind, input logic [DEV_W-1:0] dev, input logic [AW-1:0] data);
    cmd_valid = 1'b1; cmd_kind = kind; cmd_dev = dev; cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic read_cur(output int val, output bit vld);
    cmd(2'd1, DEV_LO, '0);
    val = int'(resp_data); vld = resp_valid;
  endtask

  task automatic sense(input logic [DEV_W-1:0] dev, output int val);
    cmd(2'd3, dev, '0);
    val = resp_valid ? int'(resp_data[0]) : -1;
  endtask

  // Pulse one request, wait for its trap under random priority gating.
  task automatic one_word(input logic [AW-1:0] exp_a, input bit dir, input int hold_pri);
    bit seen = 0;
    bit last_pri = 0;
    int wait_n = 0;
    dir_out = dir; xfer_req = 1'b1;
    @(negedge clk);
    xfer_req = 1'b0;
    while (!seen && wait_n < 60) begin
      if (trap_in || trap_out) begin
        seen = 1;
        check(last_pri, "R7 trap after priority", int'(last_pri), 1);
        check(bus_addr == exp_a, "R4 bus address", int'(bus_addr), int'(exp_a));
        check(trap_out == dir && trap_in == !dir, "R6 direction strobe",
              int'({trap_out, trap_in}), dir ? 2 : 1);
      end else begin
        pri_in = (wait_n >= hold_pri) && (($urandom(seed) % 4) != 0 || wait_n > 20);
        seed = seed + 1;
        #1;
        if (pri_in) check(pri_out == 1'b0, "R7 priority held while pending", int'(pri_out), 0);
        last_pri = pri_in;
        @(negedge clk);
        wait_n++;
      end
    end
    pri_in = 1'b1;
    check(seen, "R4 trap issued", int'(seen), 1);
    @(negedge clk);
    check(!(trap_in || trap_out), "R4 single strobe per request", int'({trap_out, trap_in}), 0);
  endtask

  task automatic run_block(input logic [AW-1:0] start, input int len, input bit dir, input bit chk_busy);
    logic [AW-1:0] fin;
    int v; bit vld;
    fin = exp_addr(start, len - 1);
    cmd(2'd0, DEV_LO, start);
    cmd(2'd0, DEV_HI, fin);
    cmd(2'd2, DEV_LO, '0);
    if (chk_busy) begin
      sense(DEV_LO, v);
      check(v == 0, "R3 busy after activate", v, 0);
      check(dev_connect, "R3 device connected", int'(dev_connect), 1);
    end
    for (int i = 0; i < len; i++) one_word(exp_addr(start, i), dir, (i == 0) ? 4 : 0);
    sense(DEV_LO, v);
    check(v == 1, "R5 not busy at end", v, 1);
    check(!dev_connect, "R5 device released", int'(dev_connect), 0);
    read_cur(v, vld);
    check(vld && v == int'(fin), "R5 current equals final", v, int'(fin));
  endtask

  initial begin
    int v; bit vld;
    cmd_valid = 0; cmd_kind = 0; cmd_dev = 0; cmd_data = 0;
    xfer_req = 0; dir_out = 0; dev_stop = 0; pri_in = 1; rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    check(!trap_in && !trap_out && !resp_valid, "R1 no strobe after reset", int'({trap_out, trap_in}), 0);
    sense(DEV_LO, v);  check(v == 1, "R1 not busy after reset", v, 1);
    sense(DEV_HI, v);  check(v == 0, "R1 abnormal clear after reset", v, 0);
    read_cur(v, vld);  check(vld && v == 0, "R1 current zero after reset", v, 0);

    cmd(2'd0, DEV_LO, 15'o1234);
    read_cur(v, vld);
    check(vld && v == 'o1234, "R2 load and read current", v, 'o1234);

    // R9: request while idle
    xfer_req = 1; @(negedge clk); xfer_req = 0;
    repeat (4) begin
      check(!trap_in && !trap_out, "R9 no trap while idle", int'({trap_out, trap_in}), 0);
      @(negedge clk);
    end
    read_cur(v, vld);
    check(v == 'o1234, "R9 current unchanged", v, 'o1234);

    // R11: other device addresses
    cmd(2'd0, 6'o22, 15'o777);
    cmd(2'd2, 6'o23, '0);
    read_cur(v, vld);
    check(v == 'o1234, "R11 foreign load ignored", v, 'o1234);
    cmd(2'd3, 6'o30, '0);
    check(!resp_valid, "R11 foreign sense silent", int'(resp_valid), 0);

    // single-word block and directed blocks
    run_block(15'o500, 1, 1'b0, 1'b1);
    run_block(15'o2000, 4, 1'b1, 1'b1);

    // R8: abnormal stop mid-block
    cmd(2'd0, DEV_LO, 15'd100);
    cmd(2'd0, DEV_HI, 15'd109);
    cmd(2'd2, DEV_LO, '0);
    one_word(15'd100, 1'b0, 0);
    one_word(15'd101, 1'b0, 0);
    dev_stop = 1; @(negedge clk); dev_stop = 0;
    sense(DEV_LO, v);  check(v == 1, "R8 not busy after stop", v, 1);
    sense(DEV_HI, v);  check(v == 1, "R8 abnormal flag set", v, 1);
    read_cur(v, vld);  check(v == 102, "R8 current holds next address", v, 102);
    xfer_req = 1; @(negedge clk); xfer_req = 0;
    repeat (3) begin
      check(!trap_in && !trap_out, "R9 no trap after stop", int'({trap_out, trap_in}), 0);
      @(negedge clk);
    end
    cmd(2'd2, DEV_LO, '0);
    sense(DEV_HI, v);  check(v == 0, "R8 flag cleared by activate", v, 0);

    // R10: initialize while active with a pending word
    xfer_req = 1; pri_in = 0; @(negedge clk); xfer_req = 0;
    cmd(2'd2, DEV_HI, '0);
    pri_in = 1; #1;
    check(pri_out, "R10 pending cleared by init", int'(pri_out), 1);
    sense(DEV_LO, v);  check(v == 1, "R10 not busy after init", v, 1);
    read_cur(v, vld);  check(v == 0, "R10 current cleared", v, 0);

    // random blocks
    for (int b = 0; b < 20; b++) begin
      logic [AW-1:0] st;
      int ln;
      st = AW'($urandom(seed + b) % 30000);
      ln = 1 + ($urandom(seed + 100 + b) % 8);
      run_block(st, ln, 1'(b % 2), 1'b0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule